// File: doc/BRIEF.md
# Write-Only Two-Wire Control Register Slave

This block is a two-wire (I2C) slave receiver that accepts only write transfers and uses them to load five 8-bit control registers. Each transfer has three bytes, each followed by an acknowledge clock. The first byte is the device address with the direction bit. The second byte is a sub-address whose three low bits pick the register. The third byte is the new register value.

SCL and SDA are sampled by a system clock that runs much faster than the bus, through two-flop synchronizers. START, STOP and the SCL edges are found in the system-clock domain. The block acknowledges a byte by asserting an open-drain pull-down request, which a pad outside the block turns into a low on SDA. It never stretches the clock and never returns data.

After reset the registers hold their default values. For a fixed number of system-clock cycles after reset the block is initializing, and during that time it rejects every transfer.

Top module: `i2c_ctrl_slave`

## Requirements
- R1: The device address is the 7-bit value 1,0,0,1,1 followed by `addr_pin[1]`, `addr_pin[0]` (most significant bit first). The address byte is acknowledged only when its upper seven bits equal this value. A byte that does not match gets no acknowledge and changes no register.
- R2: An address byte whose last bit (direction) is 1 gets no acknowledge, and the transfer that follows it changes no register.
- R3: The sub-address byte is acknowledged when its bits 2..0 are 0 to 4. Values 5 to 7 get no acknowledge, and the data byte that follows changes no register. Sub-address bits 7..3 are ignored.
- R4: An acknowledged data byte is loaded into the selected register on the rising SCL edge of its acknowledge clock. Before that edge the register keeps its old value. A data byte is sent most significant bit first.
- R5: While `rst_n` is low, and until the first write, the outputs are `ctl0`=FF, `ctl1`=FF, `ctl2`=90, `ctl3`=00 and `ctl4`=00 (hex).
- R6: `init_busy` is high for exactly INIT_CYCLES (default 1024) rising clock edges after `rst_n` goes high, and is low after that. While it is high, no byte is acknowledged and no register changes.
- R7: A STOP before the data acknowledge cancels the write. A repeated START after a data acknowledge begins a new write, and that write is applied.
- R8: A START in the middle of a byte discards the partial byte and restarts address reception.
- R9: `sda_pull` is high only during the acknowledge clock of an accepted byte. While SCL is high it never changes, so the slave never creates a false START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_in | input | 1 | Bus clock line, as seen at the pad |
| sda_in | input | 1 | Bus data line, as seen at the pad |
| addr_pin | input | 2 | Strapped low bits of the device address |
| sda_pull | output | 1 | Request to pull SDA low (acknowledge) |
| init_busy | output | 1 | High while post-reset initialization runs |
| ctl0 | output | 8 | Control register 0 |
| ctl1 | output | 8 | Control register 1 |
| ctl2 | output | 8 | Control register 2 |
| ctl3 | output | 8 | Control register 3 |
| ctl4 | output | 8 | Control register 4 |

## Verification
A bit counter that slips by one shifts the captured bytes. At the ports this shows up as a missing or misplaced acknowledge within the same transfer, and as a register loaded with a shifted value once that transfer ends. A phase that fails to return to idle after a rejected byte or a STOP shows up on the next transfer: a stray acknowledge, or a write that lands when it should not. Register values are read straight from the outputs after every transfer. A corrupted bank is therefore seen one transfer after the fault at the latest.

// File: rtl/i2c_ctrl_slave.sv
module i2c_ctrl_slave #(
  parameter int INIT_CYCLES = 1024,
  parameter logic [4:0] ADDR_PREFIX = 5'b10011
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [1:0] addr_pin,
  output logic       sda_pull,
  output logic       init_busy,
  output logic [7:0] ctl0,
  output logic [7:0] ctl1,
  output logic [7:0] ctl2,
  output logic [7:0] ctl3,
  output logic [7:0] ctl4
);
  localparam int NREG = 5;
  localparam int IW = $clog2(INIT_CYCLES + 1);
  localparam logic [8*NREG-1:0] DEFAULTS = {8'h00, 8'h00, 8'h90, 8'hFF, 8'hFF};

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_SUB, S_DATA} phase_t;

  logic [2:0] scl_q, sda_q;
  logic [IW-1:0] icnt;
  phase_t st;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic [2:0] idx;
  logic [7:0] bank [NREG];
  logic byte_ok;

  wire scl_rise = scl_q[1] & ~scl_q[2];
  wire scl_fall = ~scl_q[1] & scl_q[2];
  wire scl_hold = scl_q[1] & scl_q[2];
  wire start_c  = scl_hold & ~sda_q[1] & sda_q[2];
  wire stop_c   = scl_hold & sda_q[1] & ~sda_q[2];
  wire commit   = scl_rise && cnt == 4'd8 && sda_pull && st == S_DATA;

  assign init_busy = icnt != IW'(INIT_CYCLES);
  assign {ctl4, ctl3, ctl2, ctl1, ctl0} = {bank[4], bank[3], bank[2], bank[1], bank[0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) icnt <= '0;
    else if (init_busy) icnt <= icnt + 1'b1;

  always_comb
    case (st)
      S_ADDR:  byte_ok = sh == {ADDR_PREFIX, addr_pin, 1'b0} && !init_busy;
      S_SUB:   byte_ok = int'(sh[2:0]) < NREG;
      S_DATA:  byte_ok = 1'b1;
      default: byte_ok = 1'b0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      sh <= '0;
      idx <= '0;
      sda_pull <= 1'b0;
    end else if (start_c) begin
      st <= S_ADDR;
      cnt <= '0;
      sda_pull <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE;
      cnt <= '0;
      sda_pull <= 1'b0;
    end else if (st != S_IDLE) begin
      if (scl_rise) begin
        if (cnt < 4'd8) begin
          sh <= {sh[6:0], sda_q[1]};
          cnt <= cnt + 1'b1;
        end else if (cnt == 4'd8) cnt <= 4'd9;
      end
      if (scl_fall) begin
        if (cnt == 4'd8) sda_pull <= byte_ok;
        else if (cnt == 4'd9) begin
          sda_pull <= 1'b0;
          cnt <= '0;
          if (!sda_pull) st <= S_IDLE;
          else
            case (st)
              S_ADDR: st <= S_SUB;
              S_SUB: begin
                st <= S_DATA;
                idx <= sh[2:0];
              end
              default: st <= S_IDLE;
            endcase
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) bank[i] <= DEFAULTS[8*i +: 8];
    end else if (commit) begin
      bank[idx] <= sh;
    end

  assert_no_ack_in_init_R6: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |-> !sda_pull);

  assert_defaults_in_init_R5: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |-> {ctl4, ctl3, ctl2, ctl1, ctl0} == DEFAULTS);

  assert_write_only_on_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({ctl4, ctl3, ctl2, ctl1, ctl0}) |-> $past(commit));

  assert_pull_stable_scl_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q[1] && $past(scl_q[1])) |-> $stable(sda_pull));

  assert_pull_in_ack_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_q[1]);
endmodule

// File: tb/sim_i2c_ctrl_slave.sv
module sim_i2c_ctrl_slave;
  localparam int Q = 5;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic [1:0] addr_pin = 2'b10;
  logic sda_pull, init_busy;
  logic [7:0] ctl0, ctl1, ctl2, ctl3, ctl4;
  wire sda_line = sda_m & ~sda_pull;
  int checks = 0, errors = 0;
  logic [7:0] exp_r [5];
  bit disturbed;

  always #4 clk = ~clk;

  i2c_ctrl_slave u0 (.clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .addr_pin(addr_pin), .sda_pull(sda_pull), .init_busy(init_busy),
    .ctl0(ctl0), .ctl1(ctl1), .ctl2(ctl2), .ctl3(ctl3), .ctl4(ctl4));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rd(input int i);
    case (i)
      0: return ctl0;
      1: return ctl1;
      2: return ctl2;
      3: return ctl3;
      default: return ctl4;
    endcase
  endfunction

  task automatic chk_bank(input string req);
    for (int i = 0; i < 5; i++) chk(rd(i) == exp_r[i], req, rd(i), exp_r[i]);
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input bit b);
    sda_m = b; tick(Q); scl = 1'b1; tick(Q);
    if (sda_line != sda_m) disturbed = 1'b1;
    tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic ack_slot(output bit ack);
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); ack = !sda_line;
    tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    disturbed = 1'b0;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    chk(!disturbed, "R9 no pull during data bits", 32'(disturbed), 0);
    ack_slot(ack);
  endtask

  task automatic write_reg(input logic [6:0] dev, input logic [7:0] sub, input logic [7:0] dat,
                           output bit a1, output bit a2, output bit a3);
    i2c_start;
    send_byte({dev, 1'b0}, a1);
    send_byte(sub, a2);
    send_byte(dat, a3);
    i2c_stop;
  endtask

  task automatic set_defaults;
    exp_r[0] = 8'hFF; exp_r[1] = 8'hFF; exp_r[2] = 8'h90; exp_r[3] = 8'h00; exp_r[4] = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit a1, a2, a3;
    logic [6:0] me;
    set_defaults;
    tick(3);
    chk_bank("R5 defaults in reset");
    chk(sda_pull == 1'b0, "R9 idle pull in reset", 32'(sda_pull), 0);
    rst_n = 1'b1;
    tick(1023);
    chk(init_busy == 1'b1, "R6 busy at 1023", 32'(init_busy), 1);
    tick(1);
    chk(init_busy == 1'b0, "R6 idle at 1024", 32'(init_busy), 0);

    rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(1);
    me = {5'b10011, addr_pin};
    write_reg(me, 8'h00, 8'h12, a1, a2, a3);
    chk(a1 == 1'b0, "R6 nack during init", 32'(a1), 0);
    chk(init_busy == 1'b1, "R6 still busy", 32'(init_busy), 1);
    chk_bank("R6 no write during init");
    tick(1100);
    chk_bank("R5 defaults after init");

    for (int b = 0; b < 256; b++) begin
      bit exp_ack;
      exp_ack = (b[7:1] == me) && !b[0];
      i2c_start;
      send_byte(8'(b), a1);
      i2c_stop;
      chk(a1 == exp_ack, b[0] ? "R2 direction bit" : "R1 address sweep", 32'(a1), 32'(exp_ack));
    end
    chk_bank("R1 R2 sweep leaves bank");

    for (int i = 0; i < 8; i++) begin
      write_reg(me, 8'(i), 8'h30 + 8'(i), a1, a2, a3);
      chk(a2 == (i < 5), "R3 index ack", 32'(a2), 32'(i < 5));
      chk(a3 == (i < 5), "R3 data ack", 32'(a3), 32'(i < 5));
      if (i < 5) exp_r[i] = 8'h30 + 8'(i);
      chk_bank("R3 index sweep");
    end

    write_reg(me, 8'hF9, 8'hA5, a1, a2, a3);
    exp_r[1] = 8'hA5;
    chk(a2 == 1'b1, "R3 upper sub bits ignored", 32'(a2), 1);
    chk_bank("R3 upper sub bits");

    for (int p = 0; p < 4; p++) begin
      addr_pin = 2'(p);
      for (int a = 0; a < 4; a++) begin
        logic [7:0] d;
        d = {2'(p), 2'(a), 4'h5};
        write_reg({5'b10011, 2'(a)}, 8'h00, d, a1, a2, a3);
        chk(a1 == (a == p), "R1 pin strap", 32'(a1), 32'(a == p));
        if (a == p) exp_r[0] = d;
        chk(ctl0 == exp_r[0], "R1 pin strap write", ctl0, exp_r[0]);
      end
    end
    addr_pin = 2'b10;

    i2c_start;
    send_byte({me, 1'b0}, a1);
    send_byte(8'h04, a2);
    for (int i = 7; i >= 0; i--) send_bit(1'(8'hC3 >> i));
    chk(ctl4 == exp_r[4], "R4 hold before ack clock", ctl4, exp_r[4]);
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    a3 = !sda_line;
    exp_r[4] = 8'hC3;
    chk(ctl4 == 8'hC3, "R4 load on ack clock", ctl4, 8'hC3);
    chk(a3 == 1'b1, "R4 data ack", 32'(a3), 1);
    tick(Q); scl = 1'b0; tick(Q);
    i2c_stop;

    i2c_start;
    send_byte({me, 1'b0}, a1);
    send_byte(8'h02, a2);
    i2c_stop;
    chk(a2 == 1'b1, "R7 sub acked before stop", 32'(a2), 1);
    chk_bank("R7 stop cancels write");
    i2c_start;
    send_byte({me, 1'b0}, a1);
    send_byte(8'h02, a2);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    i2c_stop;
    chk_bank("R7 stop mid data");

    i2c_start;
    send_byte({me, 1'b0}, a1);
    send_byte(8'h02, a2);
    send_byte(8'h5A, a3);
    i2c_start;
    send_byte({me, 1'b0}, a1);
    send_byte(8'h03, a2);
    send_byte(8'h6B, a3);
    i2c_stop;
    exp_r[2] = 8'h5A; exp_r[3] = 8'h6B;
    chk(a3 == 1'b1, "R7 repeated start ack", 32'(a3), 1);
    chk_bank("R7 repeated start writes");

    i2c_start;
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
    i2c_start;
    send_byte({me, 1'b0}, a1);
    send_byte(8'h01, a2);
    send_byte(8'h77, a3);
    i2c_stop;
    exp_r[1] = 8'h77;
    chk(a1 == 1'b1, "R8 restart mid byte ack", 32'(a1), 1);
    chk_bank("R8 restart mid byte write");

    write_reg(me, 8'h00, 8'h01, a1, a2, a3);
    exp_r[0] = 8'h01;
    tick(3 * Q);
    chk(sda_pull == 1'b0, "R9 released after transfer", 32'(sda_pull), 0);
    chk_bank("R4 final bank");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule